// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer register value into a binary floating-point number in 64-bit double-precision layout. The source can be a signed or an unsigned integer, either 32 or 64 bits wide. The 32-bit kinds read only the low half of the word. A precision select picks the result precision. A single-precision result is rounded to 24 significant bits and then written out as the same value in double layout. A double-precision result is rounded to 53 bits.

A 32-bit source converted to double precision always fits, so that path needs no rounding and updates no status. Every other combination is rounded with the requested mode and reports three status values: whether the result is inexact, whether the significand was rounded up in magnitude, and a class code for the result. A status-valid output tells the surrounding pipeline whether it should commit that status. The block has one register stage. A conversion presented with `in_valid` appears on the outputs on the next clock edge.

Top module: `int2fp_convert`

## Requirements
- R1: `int_kind` selects the source type: 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For kinds 0 and 1, bits 63:32 of `src_word` have no effect on any output.
- R2: When `int_kind` is 0 or 1 and `to_single` is 0, the result is the exact value, `status_valid` is 0, and `inexact`, `incremented` and `fp_class` are all 0.
- R3: In every other combination the significand is rounded using `rnd_mode`: 00 = to nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. `status_valid` is 1 with the result.
- R4: When `to_single` is 1, the value is rounded to 24 significant bits and emitted in double layout. Bits 28:0 of `result` are therefore zero.
- R5: `incremented` is 1 exactly when rounding increased the magnitude of the significand.
- R6: `inexact` is 1 exactly when the rounded result differs from the exact integer value. `incremented` implies `inexact`.
- R7: An integer zero converts to +0.0 (all result bits 0) in every kind, precision and mode, with `inexact` and `incremented` both 0.
- R8: When `status_valid` is 1, `fp_class` is 5'b00100 for a positive nonzero result, 5'b01000 for a negative result, and 5'b00010 for +0.0.
- R9: Outputs are registered. `out_valid` equals `in_valid` from the previous cycle. After reset, `out_valid`, `status_valid`, the flags, the class and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A conversion request is present |
| src_word | input | 64 | Integer source word |
| int_kind | input | 2 | Source integer type code |
| to_single | input | 1 | 1 = round to single precision, 0 = double |
| rnd_mode | input | 2 | Rounding mode code |
| out_valid | output | 1 | Result registered from the previous cycle |
| result | output | 64 | Floating-point result in double layout |
| inexact | output | 1 | Rounded result differs from the exact value |
| incremented | output | 1 | Significand rounded up in magnitude |
| fp_class | output | 5 | Result class code |
| status_valid | output | 1 | Status outputs are to be committed |

## Verification
The bound checker watches relations that must hold on every cycle:
- the one-cycle valid latency;
- quiet status whenever `status_valid` is low;
- `incremented` implying `inexact`;
- the class code agreeing with the sign and zero-ness of the result;
- zero low fraction bits for single-precision results.

Only the bench's sweeps can show that the rounded value itself is correct. They cover each rounding mode, ties broken toward the even significand, carries out of the significand that bump the exponent, and the extreme integers of each type. They also check that upper-half bits are ignored for 32-bit sources. These are compared against an arithmetic reference built from quotient and remainder rather than guard and sticky bits.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int XLEN     = 64;
  localparam int HALF     = XLEN / 2;
  localparam int DP_PREC  = 53;
  localparam int SP_PREC  = 24;
  localparam int DP_FRAC  = DP_PREC - 1;
  localparam int SP_FRAC  = SP_PREC - 1;
  localparam int DP_EXPW  = 11;
  localparam int DP_BIAS  = 1023;
  localparam int CLASS_W  = 5;
  localparam int LZ_W     = $clog2(XLEN) + 1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_ZERO      = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rnd_mode_e;

  localparam logic [CLASS_W-1:0] CLS_POS_NORM = 5'b00100;
  localparam logic [CLASS_W-1:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [CLASS_W-1:0] CLS_POS_ZERO = 5'b00010;
endpackage

// File: rtl/i2f_unpack.sv
module i2f_unpack
  import i2f_pkg::*;
(
  input  logic [XLEN-1:0] word,
  input  logic [1:0]      kind,
  output logic            neg,
  output logic [XLEN-1:0] mag
);
  logic [HALF-1:0] lo;
  assign lo = word[HALF-1:0];

  always_comb begin
    neg = 1'b0;
    mag = {{HALF{1'b0}}, lo};
    case (kind)
      2'd0: begin
        neg = lo[HALF-1];
        mag = neg ? {{HALF{1'b0}}, (~lo) + 1'b1} : {{HALF{1'b0}}, lo};
      end
      2'd1: mag = {{HALF{1'b0}}, lo};
      2'd2: begin
        neg = word[XLEN-1];
        mag = neg ? (~word) + 1'b1 : word;
      end
      default: mag = word;
    endcase
  end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
(
  input  logic [XLEN-1:0]  norm,
  input  logic             neg,
  input  logic             single,
  input  logic [1:0]       rm,
  output logic [DP_PREC:0] sum,
  output logic             carry,
  output logic             inexact,
  output logic             incr
);
  localparam int DP_G = XLEN - 1 - DP_PREC;
  localparam int SP_G = XLEN - 1 - SP_PREC;

  logic [DP_PREC-1:0] sig;
  logic               guard, sticky, lsb;

  always_comb begin
    if (single) begin
      sig    = {{(DP_PREC-SP_PREC){1'b0}}, norm[XLEN-1 -: SP_PREC]};
      guard  = norm[SP_G];
      sticky = |norm[SP_G-1:0];
    end else begin
      sig    = norm[XLEN-1 -: DP_PREC];
      guard  = norm[DP_G];
      sticky = |norm[DP_G-1:0];
    end
    lsb     = sig[0];
    inexact = guard | sticky;
    case (rnd_mode_e'(rm))
      RM_NEAR_EVEN: incr = guard & (sticky | lsb);
      RM_ZERO:      incr = 1'b0;
      RM_UP:        incr = ~neg & inexact;
      default:      incr = neg & inexact;
    endcase
    sum   = {1'b0, sig} + {{DP_PREC{1'b0}}, incr};
    carry = single ? sum[SP_PREC] : sum[DP_PREC];
  end
endmodule

// File: rtl/int2fp_convert.sv
module int2fp_convert
  import i2f_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [XLEN-1:0]    src_word,
  input  logic [1:0]         int_kind,
  input  logic               to_single,
  input  logic [1:0]         rnd_mode,
  output logic               out_valid,
  output logic [XLEN-1:0]    result,
  output logic               inexact,
  output logic               incremented,
  output logic [CLASS_W-1:0] fp_class,
  output logic               status_valid
);
  logic               neg;
  logic [XLEN-1:0]    mag, norm;
  logic [LZ_W-1:0]    lz;
  logic [DP_PREC:0]   sum;
  logic               carry, rnd_inx, rnd_inc;
  logic               is_zero, round_path;
  logic [DP_EXPW-1:0] exp_b;
  logic [DP_FRAC-1:0] frac;
  logic [XLEN-1:0]    res_d;
  logic [CLASS_W-1:0] cls_d;

  i2f_unpack u_unpack (.word(src_word), .kind(int_kind), .neg(neg), .mag(mag));

  i2f_lzc #(.W(XLEN)) u_lzc (.v(mag), .count(lz));

  assign norm = mag << lz[LZ_W-2:0];

  i2f_round u_round (
    .norm(norm), .neg(neg), .single(to_single), .rm(rnd_mode),
    .sum(sum), .carry(carry), .inexact(rnd_inx), .incr(rnd_inc)
  );

  assign is_zero    = (mag == '0);
  assign round_path = int_kind[1] | to_single;

  always_comb begin
    exp_b = DP_EXPW'(DP_BIAS + (XLEN - 1)) - DP_EXPW'(lz) + DP_EXPW'(carry);
    if (to_single) frac = {sum[SP_FRAC-1:0], {(DP_FRAC-SP_FRAC){1'b0}}};
    else           frac = sum[DP_FRAC-1:0];
    res_d = is_zero ? '0 : {neg, exp_b, frac};
    cls_d = is_zero ? CLS_POS_ZERO : (neg ? CLS_NEG_NORM : CLS_POS_NORM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      inexact      <= 1'b0;
      incremented  <= 1'b0;
      fp_class     <= '0;
      status_valid <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      status_valid <= in_valid & round_path;
      inexact      <= in_valid & round_path & ~is_zero & rnd_inx;
      incremented  <= in_valid & round_path & ~is_zero & rnd_inc;
      fp_class     <= (in_valid & round_path) ? cls_d : '0;
      if (in_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk
  import i2f_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               to_single,
  input logic               out_valid,
  input logic [XLEN-1:0]    result,
  input logic               inexact,
  input logic               incremented,
  input logic [CLASS_W-1:0] fp_class,
  input logic               status_valid
);
  logic single_q;
  always_ff @(posedge clk) single_q <= to_single;

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  assert_status_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> out_valid);

  assert_quiet_status_R2: assert property (@(posedge clk) disable iff (rst)
    !status_valid |-> (!inexact && !incremented && fp_class == '0));

  assert_incr_implies_inexact_R6: assert property (@(posedge clk) disable iff (rst)
    incremented |-> inexact);

  assert_class_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> ($onehot0(fp_class) && fp_class != '0));

  assert_class_sign_R8: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> ((fp_class == CLS_NEG_NORM) == result[XLEN-1]));

  assert_zero_exact_R7: assert property (@(posedge clk) disable iff (rst)
    (status_valid && fp_class == CLS_POS_ZERO) |-> (result == '0 && !inexact));

  assert_single_low_frac_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst) && single_q) |-> (result[DP_FRAC-SP_FRAC-1:0] == '0));
endmodule

bind int2fp_convert i2f_convert_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .to_single(to_single),
  .out_valid(out_valid), .result(result), .inexact(inexact),
  .incremented(incremented), .fp_class(fp_class), .status_valid(status_valid)
);

// File: tb/int2fp_convert_tb_top.sv
module int2fp_convert_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_word = '0;
  logic [1:0]  int_kind = '0;
  logic        to_single = 1'b0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid, inexact, incremented, status_valid;
  logic [63:0] result;
  logic [4:0]  fp_class;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  int2fp_convert dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
    .int_kind(int_kind), .to_single(to_single), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .result(result), .inexact(inexact),
    .incremented(incremented), .fp_class(fp_class), .status_valid(status_valid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input logic [63:0] w, input int k, input int s, input int rm);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s src=%h kind=%0d single=%0d rm=%0d actual=%h expected=%h",
               tag, w, k, s, rm, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // Arithmetic reference: quotient/remainder rounding
  task automatic ref_conv(input logic [63:0] w, input int k, input int sgl, input int rm,
                          output logic [63:0] r, output logic inx, output logic inc,
                          output logic [4:0] cls, output logic sv);
    logic        sign;
    logic [63:0] m, q, rem, half;
    int          e, p, sh;
    logic        up;
    sign = 1'b0;
    case (k)
      0: begin sign = w[31]; m = sign ? {32'b0, 32'(-w[31:0])} : {32'b0, w[31:0]}; end
      1: m = {32'b0, w[31:0]};
      2: begin sign = w[63]; m = sign ? -w : w; end
      default: m = w;
    endcase
    sv  = (k >= 2) || (sgl != 0);
    p   = (sgl != 0) ? 24 : 53;
    inx = 1'b0; inc = 1'b0;
    if (m == 0) begin
      r = '0;
      cls = sv ? 5'b00010 : 5'b00000;
      return;
    end
    e = 0;
    for (int i = 0; i < 64; i++) if (m[i]) e = i;
    if (e < p) begin
      q = m << (p - 1 - e);
    end else begin
      sh   = e - p + 1;
      q    = m >> sh;
      rem  = m - (q << sh);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 0);
      case (rm)
        0: up = (rem > half) || (rem == half && q[0]);
        1: up = 1'b0;
        2: up = !sign && inx;
        default: up = sign && inx;
      endcase
      inc = up;
      q = q + 64'(up);
      if (q == (64'd1 << p)) begin q = q >> 1; e = e + 1; end
    end
    r = {sign, 11'(e + 1023), 52'((q & ((64'd1 << (p - 1)) - 1)) << (53 - p))};
    cls = sv ? (sign ? 5'b01000 : 5'b00100) : 5'b00000;
    if (!sv) begin inx = 1'b0; inc = 1'b0; end
  endtask

  function automatic logic [63:0] pattern(input int idx, input logic [63:0] rnd);
    case (idx)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'hFFFF_FFFF_FFFF_FFFF;
      3:  return 64'h8000_0000_0000_0000;
      4:  return 64'h7FFF_FFFF_FFFF_FFFF;
      5:  return 64'h0000_0000_8000_0000;
      6:  return 64'h0000_0000_7FFF_FFFF;
      7:  return 64'h0000_0000_0100_0001;
      8:  return 64'h0000_0000_0200_0002;
      9:  return 64'h0000_0000_0200_0006;
      10: return 64'h0020_0000_0000_0001;
      11: return 64'h0040_0000_0000_0002;
      12: return 64'h0040_0000_0000_0006;
      13: return 64'hDEAD_BEEF_0000_0005;
      14: return 64'h1234_5678_FFFF_FFFB;
      15: return 64'hFFFF_FFFF_FEFF_FFFF;
      16: return 64'h00FF_FFFF_FFFF_FFFF;
      17: return 64'h0000_0000_00FF_FFFF;
      18: return 64'h0000_0000_01FF_FFFF;
      19: return 64'hA5A5_0000_0000_0000;
      20: return 64'hFFE0_0000_0000_0001;
      21: return 64'hFFFF_FFFF_0000_0000;
      default: return rnd;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] lfsr, w, er;
    logic        ei, ec, esv;
    logic [4:0]  ecl;
    string       tag;
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 reset out_valid", 64'(out_valid), 64'd0, 0, 0, 0, 0);
    check("R9 reset result", result, 64'd0, 0, 0, 0, 0);
    check("R9 reset status", {58'd0, fp_class, status_valid}, 64'd0, 0, 0, 0, 0);

    for (int pi = 0; pi < 36; pi++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      w = pattern(pi, lfsr);
      for (int k = 0; k < 4; k++)
        for (int s = 0; s < 2; s++)
          for (int rm = 0; rm < 4; rm++) begin
            in_valid = 1'b1; src_word = w; int_kind = 2'(k);
            to_single = s[0]; rnd_mode = 2'(rm);
            @(negedge clk);
            in_valid = 1'b0;
            ref_conv(w, k, s, rm, er, ei, ec, ecl, esv);
            if (k < 2 && s == 0) tag = "R2 exact path result";
            else if (w == 0 || (k < 2 && w[31:0] == 0)) tag = "R7 zero result";
            else if (s == 1) tag = "R4 single result";
            else tag = "R3 rounded result";
            check(tag, result, er, w, k, s, rm);
            if (k < 2 && w[63:32] != 0) check("R1 upper bits ignored", result, er, w, k, s, rm);
            check("R9 out_valid", 64'(out_valid), 64'd1, w, k, s, rm);
            check("R2 status_valid", 64'(status_valid), 64'(esv), w, k, s, rm);
            check("R5 incremented", 64'(incremented), 64'(ec), w, k, s, rm);
            check("R6 inexact", 64'(inexact), 64'(ei), w, k, s, rm);
            check("R8 class", 64'(fp_class), 64'(ecl), w, k, s, rm);
          end
    end
    // R9: idle cycle drops valid
    @(negedge clk);
    check("R9 idle out_valid", 64'(out_valid), 64'd0, 0, 0, 0, 0);
    check("R9 idle status_valid", 64'(status_valid), 64'd0, 0, 0, 0, 0);
    finish_run();
  end
endmodule